// File: doc/BRIEF.md
# I2C Line Spike Filter

This block sits between the SCL and SDA pads of an I2C interface and the protocol logic. It brings each raw line into the kernel clock domain through a two-stage synchroniser. It then passes the line through a digital glitch filter whose length is set at run time. A line's filtered level moves to a new value only once the synchronised input has stayed at that value for more kernel clock cycles than the programmed length. Shorter spikes never reach the protocol logic.

Each line gets a clean level and two one-cycle strobes, one for each edge direction, so the protocol decoder can react to START, STOP and clock edges without keeping its own history. A length of zero turns the filter into a plain pass-through of the synchronised input. The length input is meant to change only while the interface is idle and disabled.

Top module: `i2c_line_filter`

## Requirements
- R1: While reset is applied and after it is released, with both raw lines idle high, scl_flt and sda_flt read 1 and all four edge strobes read 0.
- R2: If a raw line changes and then holds its new level, the matching filtered output takes that level on the (flt_len + 3)-th rising clock edge, counting the first edge that samples the new raw level as edge 1.
- R3: A raw pulse that lasts flt_len or fewer clock cycles causes no change on the filtered output and no strobe.
- R4: A raw pulse that lasts flt_len + 1 or more clock cycles is passed, giving exactly one falling and one rising strobe on that line.
- R5: With flt_len = 0 there is no filtering: a raw pulse of a single clock cycle is passed to the filtered output.
- R6: The stability count starts again whenever the synchronised input returns to the current filtered level. Two short runs of a new level split by one cycle at the old level do not add up.
- R7: SCL and SDA are filtered independently. Activity on one line produces no strobe and no level change on the other.
- R8: A rise strobe (scl_rise, sda_rise) is 1 for exactly the one cycle in which its filtered level goes 0 to 1. A fall strobe (scl_fall, sda_fall) is 1 for exactly the one cycle in which its filtered level goes 1 to 0. Rise and fall of one line are never 1 together.
- R9: All four bits of flt_len are used: at flt_len = 15 a 15-cycle pulse is suppressed and a 16-cycle pulse is passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flt_len | input | 4 | Filter length in kernel clocks; 0 selects pass-through |
| scl_raw | input | 1 | Asynchronous SCL pad level |
| sda_raw | input | 1 | Asynchronous SDA pad level |
| scl_flt | output | 1 | Filtered SCL level |
| sda_flt | output | 1 | Filtered SDA level |
| scl_rise | output | 1 | One-cycle strobe on filtered SCL going high |
| scl_fall | output | 1 | One-cycle strobe on filtered SCL going low |
| sda_rise | output | 1 | One-cycle strobe on filtered SDA going high |
| sda_fall | output | 1 | One-cycle strobe on filtered SDA going low |

## Verification
The bench targets the pass/suppress boundary at each tested length: a pulse of exactly flt_len cycles and one of flt_len + 1 cycles. A comparison off by one in either direction would let through one of these or block the other. It measures the exact latency edge, which catches an extra or missing pipeline register. It also sends two interrupted low runs whose total length exceeds the threshold; a counter that fails to restart would pass them as one pulse. The zero setting, the full-scale setting, and pulses on one line while the other is watched expose a missing bypass, a truncated length field and crosstalk between the lanes.

// File: rtl/i2c_flt_pkg.sv
package i2c_flt_pkg;
  localparam int unsigned FLT_LEN_W  = 4;
  localparam int unsigned SYNC_DEPTH = 2;
  localparam int unsigned NUM_LINES  = 2;
  localparam int unsigned LINE_SCL   = 0;
  localparam int unsigned LINE_SDA   = 1;
  localparam logic        IDLE_LEVEL = 1'b1;
endpackage

// File: rtl/i2c_flt_rst_sync.sv
module i2c_flt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/i2c_flt_sync.sv
module i2c_flt_sync #(
  parameter int unsigned DEPTH    = i2c_flt_pkg::SYNC_DEPTH,
  parameter logic        RST_LVL  = i2c_flt_pkg::IDLE_LEVEL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] chain_q;
  logic [DEPTH-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {DEPTH{RST_LVL}};
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[DEPTH-1];
endmodule

// File: rtl/i2c_flt_lane.sv
module i2c_flt_lane #(
  parameter int unsigned LEN_W = i2c_flt_pkg::FLT_LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] len,
  input  logic             smp,
  output logic             lvl,
  output logic             rise,
  output logic             fall
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             rise_q, rise_d;
  logic             fall_q, fall_d;
  logic             differ;
  logic             flip;

  // next-state logic
  always_comb begin
    differ = (smp != lvl_q);
    flip   = differ && (cnt_q >= len);
    lvl_d  = flip ? smp : lvl_q;
    if (!differ || flip) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
    rise_d = flip &&  smp;
    fall_d = flip && !smp;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lvl_q  <= i2c_flt_pkg::IDLE_LEVEL;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lvl_q  <= lvl_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign lvl  = lvl_q;
  assign rise = rise_q;
  assign fall = fall_q;

  // R8
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_q && fall_q));

  // R8
  rise_marks_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> (lvl_q && !$past(lvl_q)));

  // R8
  change_has_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> (rise_q || fall_q));

  // R2
  follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> ($past(smp) == lvl_q));

  // R6
  count_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(smp) == $past(lvl_q)) |-> (cnt_q == '0));
endmodule

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned LEN_W = i2c_flt_pkg::FLT_LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] flt_len,
  input  logic             scl_raw,
  input  logic             sda_raw,
  output logic             scl_flt,
  output logic             sda_flt,
  output logic             scl_rise,
  output logic             scl_fall,
  output logic             sda_rise,
  output logic             sda_fall
);
  import i2c_flt_pkg::*;

  localparam int unsigned LINES = NUM_LINES;

  logic             srst_n;
  logic [LINES-1:0] raw_v, smp_v, lvl_v, rise_v, fall_v;

  i2c_flt_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign raw_v[LINE_SCL] = scl_raw;
  assign raw_v[LINE_SDA] = sda_raw;

  for (genvar g = 0; g < LINES; g++) begin : g_lane
    i2c_flt_sync #(.DEPTH(SYNC_DEPTH), .RST_LVL(IDLE_LEVEL)) u_sync (
      .clk   (clk),
      .rst_n (srst_n),
      .din   (raw_v[g]),
      .dout  (smp_v[g])
    );

    i2c_flt_lane #(.LEN_W(LEN_W)) u_lane (
      .clk   (clk),
      .rst_n (srst_n),
      .len   (flt_len),
      .smp   (smp_v[g]),
      .lvl   (lvl_v[g]),
      .rise  (rise_v[g]),
      .fall  (fall_v[g])
    );
  end

  assign scl_flt  = lvl_v[LINE_SCL];
  assign sda_flt  = lvl_v[LINE_SDA];
  assign scl_rise = rise_v[LINE_SCL];
  assign scl_fall = fall_v[LINE_SCL];
  assign sda_rise = rise_v[LINE_SDA];
  assign sda_fall = fall_v[LINE_SDA];
endmodule

// File: tb/i2c_line_filter_bench.sv
module i2c_line_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] flt_len;
  logic       scl_raw, sda_raw;
  logic       scl_flt, sda_flt, scl_rise, scl_fall, sda_rise, sda_fall;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  i2c_line_filter u_i2c_line_filter (
    .clk(clk), .rst_n(rst_n), .flt_len(flt_len),
    .scl_raw(scl_raw), .sda_raw(sda_raw),
    .scl_flt(scl_flt), .sda_flt(sda_flt),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_rise(sda_rise), .sda_fall(sda_fall)
  );

  // vectors: length, pulse width, pulse expected to pass
  localparam int NV = 10;
  localparam int V_LEN [NV] = '{1, 1, 2, 2, 5, 5, 15, 15, 0, 7};
  localparam int V_WID [NV] = '{1, 2, 2, 3, 5, 6, 15, 16, 1, 3};
  localparam int V_PASS[NV] = '{0, 1, 0, 1, 0, 1, 0,  1,  1, 0};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic get_lvl(input int ln);
    return (ln == 0) ? scl_flt : sda_flt;
  endfunction

  // drive a low pulse of wid cycles on one line, count strobes on both lines
  task automatic pulse(input int ln, input int wid, input int tail,
                       output int nf, output int nr, output int oth);
    nf = 0; nr = 0; oth = 0;
    @(negedge clk);
    if (ln == 0) scl_raw = 1'b0; else sda_raw = 1'b0;
    for (int i = 1; i <= wid + tail; i++) begin
      @(negedge clk);
      if (ln == 0) begin
        nf += int'(scl_fall); nr += int'(scl_rise); oth += int'(sda_fall) + int'(sda_rise);
      end else begin
        nf += int'(sda_fall); nr += int'(sda_rise); oth += int'(scl_fall) + int'(scl_rise);
      end
      if (i == wid) begin
        if (ln == 0) scl_raw = 1'b1; else sda_raw = 1'b1;
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int nf, nr, oth;
    rst_n = 1'b0; flt_len = 4'd0; scl_raw = 1'b1; sda_raw = 1'b1;
    idle(4);
    // R1 during reset
    check(scl_flt && sda_flt && !scl_rise && !scl_fall && !sda_rise && !sda_fall,
          "R1 in reset", {scl_flt, sda_flt, scl_rise, scl_fall, sda_rise, sda_fall}, 6'b110000);
    rst_n = 1'b1;
    idle(6);
    // R1 after release
    check(scl_flt && sda_flt && !scl_rise && !scl_fall && !sda_rise && !sda_fall,
          "R1 after reset", {scl_flt, sda_flt, scl_rise, scl_fall, sda_rise, sda_fall}, 6'b110000);

    // vector table: R3, R4, R5, R7, R9
    for (int v = 0; v < NV; v++) begin
      flt_len = 4'(V_LEN[v]);
      idle(3);
      pulse(v % 2, V_WID[v], V_LEN[v] + 8, nf, nr, oth);
      check(nf == V_PASS[v], $sformatf("R3/R4 vec%0d fall count (R5 R9)", v), nf, V_PASS[v]);
      check(nr == V_PASS[v], $sformatf("R4 vec%0d rise count", v), nr, V_PASS[v]);
      check(oth == 0, $sformatf("R7 vec%0d other line strobes", v), oth, 0);
      check(get_lvl(v % 2) == 1'b1, $sformatf("R3 vec%0d level restored", v), get_lvl(v % 2), 1);
    end

    // R2 latency on SCL with length 3, then SDA with length 0
    for (int k = 0; k < 2; k++) begin
      int L;
      L = (k == 0) ? 3 : 0;
      flt_len = 4'(L);
      idle(3);
      if (k == 0) scl_raw = 1'b0; else sda_raw = 1'b0;
      for (int s = 1; s <= L + 4; s++) begin
        @(negedge clk);
        if (s == L + 2)
          check(get_lvl(k) == 1'b1, "R2 not yet changed", get_lvl(k), 1);
        if (s == L + 3) begin
          check(get_lvl(k) == 1'b0, "R2 changed on edge L+3", get_lvl(k), 0);
          check(((k == 0) ? scl_fall : sda_fall) == 1'b1, "R8 fall strobe with change",
                (k == 0) ? scl_fall : sda_fall, 1);
        end
        if (s == L + 4) begin
          check(((k == 0) ? scl_fall : sda_fall) == 1'b0, "R8 fall strobe one cycle",
                (k == 0) ? scl_fall : sda_fall, 0);
          check(get_lvl(1 - k) == 1'b1, "R7 other line held", get_lvl(1 - k), 1);
        end
      end
      if (k == 0) scl_raw = 1'b1; else sda_raw = 1'b1;
      for (int s = 1; s <= L + 4; s++) begin
        @(negedge clk);
        if (s == L + 3) begin
          check(get_lvl(k) == 1'b1, "R2 rise on edge L+3", get_lvl(k), 1);
          check(((k == 0) ? scl_rise : sda_rise) == 1'b1, "R8 rise strobe",
                (k == 0) ? scl_rise : sda_rise, 1);
        end
        if (s == L + 4)
          check(((k == 0) ? scl_rise : sda_rise) == 1'b0, "R8 rise strobe one cycle",
                (k == 0) ? scl_rise : sda_rise, 0);
      end
    end

    // R6 restart: length 4, low 3, high 1, low 3
    flt_len = 4'd4;
    idle(3);
    nf = 0;
    scl_raw = 1'b0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      nf += int'(scl_fall);
      if (i == 3) scl_raw = 1'b1;
      if (i == 4) scl_raw = 1'b0;
      if (i == 7) scl_raw = 1'b1;
    end
    check(nf == 0, "R6 interrupted runs do not accumulate", nf, 0);
    check(scl_flt == 1'b1, "R6 level unchanged", scl_flt, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule